// File: doc/BRIEF.md
# Serial DAC Word Loader

This block feeds a double-buffered serial digital-to-analog converter over three wires: a data line, a shift clock and an active-low load strobe. A producer offers a 12-bit code on a valid/ready stream port. The loader takes the code, sends it most significant bit first with one rising shift-clock edge per bit, and then pulses the load strobe low. That pulse moves the shifted word into the converter's output register. Until the strobe arrives, the converter keeps the previous word in its output register.

All analog-side timing comes from counts of system-clock cycles. Five parameters give minimum times in nanoseconds: data setup, data hold, clock high, clock low and load pulse width. A further parameter gives the system clock period. Each minimum time becomes a whole number of cycles. The low phase must cover both the low time and the setup time. The high phase must cover both the high time and the hold time.

Back-pressure: ready is high only while the loader is idle. A word transfers on a cycle where valid and ready are both high. A producer that holds valid high while ready is low simply waits. Nothing it presents during that time is taken, whatever its data.

Top module: `sdac_loader`

## Requirements
- R1: With `rst` low, a word is accepted exactly on a cycle where `word_valid` and `word_ready` are both high. `word_ready` is high whenever the loader is idle.
- R2: `word_ready` falls on the cycle after acceptance. It stays low until the load pulse has ended. Valid and data presented while ready is low have no effect. `busy` is the inverse of `word_ready`.
- R3: Each word produces exactly 12 rising edges of `ser_clk`. On the n-th edge (n = 1..12), `ser_data` carries bit 12-n of the word, so bit 11 goes first.
- R4: `ser_data` changes only in cycles where `ser_clk` is low.
- R5: Each low phase of `ser_clk` lasts ceil(max(low, setup)/period) cycles. The data for a bit is valid for that whole phase before the rising edge.
- R6: Each high phase of `ser_clk` lasts ceil(max(high, hold)/period) cycles. The data is held throughout it.
- R7: After the 12th high phase, `load_n` goes low for exactly ceil(load/period) cycles while `ser_clk` stays low. The converter's output register keeps its old word until that pulse.
- R8: Every cycle count uses ceil(ns/period) with a minimum of 1. With the defaults (8 ns period; 40/80/90/120/120 ns), a word takes 15 low cycles plus 12 high cycles per bit, then 15 load cycles. Ready therefore returns 339 cycles after acceptance.
- R9: A synchronous active-high `rst` returns the loader to idle within one clock. In that state `ser_clk` is 0, `load_n` is 1, `word_ready` is 1 and `busy` is 0, even in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Producer offers a word |
| word_ready | output | 1 | Loader idle and able to take a word |
| word_data | input | 12 | Code to send, bit 11 first |
| ser_data | output | 1 | Serial data line to the converter |
| ser_clk | output | 1 | Shift clock; the converter samples on its rising edge |
| load_n | output | 1 | Active-low strobe that commits the shifted word |
| busy | output | 1 | High from acceptance until the load pulse ends |

## Verification
The bench sends codes chosen to expose wrong bit order or stuck lines: all zeros, all ones, a lone MSB, a lone LSB and alternating patterns. Its receiver model rebuilds each word from the rising edges. A reversed shift or an off-by-one bit index would latch the wrong code, and an extra or missing edge would trip the bit count at the strobe. It pulses valid with foreign data while the loader is busy. A handshake that ignored ready would then commit that data or restart the sequence. It holds a second word pending back to back, to catch an early ready or one that never returns. It resets in the middle of a word, where a loader that kept counting, or strobed, would corrupt the converter's old value. Every cycle is compared against the exact phase lengths. A rounding error in any cycle conversion therefore shows up as a timing mismatch.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOAD = 2'd3
  } sdac_state_e;

  // whole cycles covering a minimum time, never fewer than one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdac_phase_timer.sv
module sdac_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  // a phase started with len lasts len cycles: len-1 down to 0
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= len - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] din,
  output logic              msb,
  output logic              last
);

  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] sreg;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      idx  <= '0;
    end else if (load) begin
      sreg <= din;
      idx  <= '0;
    end else if (shift) begin
      sreg <= {sreg[WORD_W-2:0], 1'b0};
      idx  <= idx + IDX_W'(1);
    end
  end

  assign msb  = sreg[WORD_W-1];
  assign last = (idx == IDX_W'(WORD_W - 1));

endmodule

// File: rtl/sdac_seq_ctrl.sv
module sdac_seq_ctrl
  import sdac_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int LOW_CYC  = 15,
  parameter int HIGH_CYC = 12,
  parameter int LOAD_CYC = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             last_bit,
  input  logic             phase_done,
  output logic             accept,
  output logic             shift,
  output logic             t_start,
  output logic [CNT_W-1:0] t_len,
  output logic             ready_o,
  output logic             sclk_o,
  output logic             load_n_o
);

  localparam logic [CNT_W-1:0] LOW_LEN  = CNT_W'(LOW_CYC);
  localparam logic [CNT_W-1:0] HIGH_LEN = CNT_W'(HIGH_CYC);
  localparam logic [CNT_W-1:0] LOAD_LEN = CNT_W'(LOAD_CYC);

  sdac_state_e st, nxt;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  always_comb begin
    nxt     = st;
    accept  = 1'b0;
    shift   = 1'b0;
    t_start = 1'b0;
    t_len   = '0;
    unique case (st)
      ST_IDLE: begin
        if (in_valid) begin
          accept  = 1'b1;
          t_start = 1'b1;
          t_len   = LOW_LEN;
          nxt     = ST_LOW;
        end
      end
      ST_LOW: begin
        if (phase_done) begin
          t_start = 1'b1;
          t_len   = HIGH_LEN;
          nxt     = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (phase_done) begin
          t_start = 1'b1;
          if (last_bit) begin
            t_len = LOAD_LEN;
            nxt   = ST_LOAD;
          end else begin
            shift = 1'b1;
            t_len = LOW_LEN;
            nxt   = ST_LOW;
          end
        end
      end
      ST_LOAD: begin
        if (phase_done) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // pins decode straight from the state register
  assign ready_o  = (st == ST_IDLE);
  assign sclk_o   = (st == ST_HIGH);
  assign load_n_o = (st != ST_LOAD);

endmodule

// File: rtl/sdac_loader.sv
module sdac_loader
  import sdac_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int CLK_NS    = 8,
  parameter int SETUP_NS  = 40,
  parameter int HOLD_NS   = 80,
  parameter int HIGH_NS   = 90,
  parameter int LOW_NS    = 120,
  parameter int STROBE_NS = 120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              load_n,
  output logic              busy
);

  localparam int LOW_CYC  = ns_to_cyc(max2(LOW_NS, SETUP_NS), CLK_NS);
  localparam int HIGH_CYC = ns_to_cyc(max2(HIGH_NS, HOLD_NS), CLK_NS);
  localparam int LOAD_CYC = ns_to_cyc(STROBE_NS, CLK_NS);
  localparam int MAX_CYC  = max2(max2(LOW_CYC, HIGH_CYC), LOAD_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic             accept, shift, t_start, phase_done, last_bit, ready_i;
  logic [CNT_W-1:0] t_len;

  sdac_seq_ctrl #(
    .CNT_W(CNT_W), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .LOAD_CYC(LOAD_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(word_valid), .last_bit(last_bit),
    .phase_done(phase_done), .accept(accept), .shift(shift),
    .t_start(t_start), .t_len(t_len), .ready_o(ready_i),
    .sclk_o(ser_clk), .load_n_o(load_n)
  );

  sdac_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start(t_start), .len(t_len), .expired(phase_done)
  );

  sdac_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .shift(shift), .din(word_data),
    .msb(ser_data), .last(last_bit)
  );

  assign word_ready = ready_i;
  assign busy       = ~ready_i;

endmodule

// File: rtl/sdac_loader_chk.sv
module sdac_loader_chk
  import sdac_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int CLK_NS    = 8,
  parameter int SETUP_NS  = 40,
  parameter int HOLD_NS   = 80,
  parameter int HIGH_NS   = 90,
  parameter int LOW_NS    = 120,
  parameter int STROBE_NS = 120
) (
  input logic clk,
  input logic rst,
  input logic word_valid,
  input logic word_ready,
  input logic ser_data,
  input logic ser_clk,
  input logic load_n
);

  localparam logic [15:0] LOW_C  = 16'(ns_to_cyc(max2(LOW_NS, SETUP_NS), CLK_NS));
  localparam logic [15:0] HIGH_C = 16'(ns_to_cyc(max2(HIGH_NS, HOLD_NS), CLK_NS));
  localparam logic [15:0] LOAD_C = 16'(ns_to_cyc(STROBE_NS, CLK_NS));
  localparam logic [15:0] BITS_C = 16'(WORD_W);

  logic        rst_d, prev_clk;
  logic [15:0] lo_cnt, hi_cnt, ld_cnt, edge_cnt;

  always_ff @(posedge clk) begin
    rst_d    <= rst;
    prev_clk <= ser_clk;
    if (rst) begin
      lo_cnt   <= '0;
      hi_cnt   <= '0;
      ld_cnt   <= '0;
      edge_cnt <= '0;
    end else begin
      if (ser_clk) lo_cnt <= '0;
      else if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 16'd1;
      if (!ser_clk) hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
      if (load_n) ld_cnt <= '0;
      else if (ld_cnt != 16'hFFFF) ld_cnt <= ld_cnt + 16'd1;
      if (word_valid && word_ready) edge_cnt <= '0;
      else if (ser_clk && !prev_clk) edge_cnt <= edge_cnt + 16'd1;
    end
  end

  // R1: acceptance leaves idle on the next cycle
  a_r1_accept_drops_ready: assert property (@(posedge clk) disable iff (rst || rst_d)
    (word_valid && word_ready) |=> !word_ready);

  // R2: ready only comes back straight after a load pulse
  a_r2_ready_after_load: assert property (@(posedge clk) disable iff (rst || rst_d)
    $rose(word_ready) |-> $past(!load_n));

  // R3: strobe follows exactly one word of rising edges
  a_r3_edges_per_word: assert property (@(posedge clk) disable iff (rst || rst_d)
    $fell(load_n) |-> (edge_cnt == BITS_C));

  // R4: data line moves only while the shift clock is low
  a_r4_data_moves_low: assert property (@(posedge clk) disable iff (rst || rst_d)
    (ser_data != $past(ser_data)) |-> !ser_clk);

  // R5: low phase long enough before each rising edge
  a_r5_low_width: assert property (@(posedge clk) disable iff (rst || rst_d)
    $rose(ser_clk) |-> (lo_cnt >= LOW_C));

  // R6: high phase length
  a_r6_high_width: assert property (@(posedge clk) disable iff (rst || rst_d)
    $fell(ser_clk) |-> (hi_cnt == HIGH_C));

  // R7: strobe width and clock quiet during strobe
  a_r7_strobe_width: assert property (@(posedge clk) disable iff (rst || rst_d)
    $rose(load_n) |-> (ld_cnt == LOAD_C));

  a_r7_clk_low_in_strobe: assert property (@(posedge clk) disable iff (rst || rst_d)
    !load_n |-> !ser_clk);

endmodule

bind sdac_loader sdac_loader_chk #(
  .WORD_W(WORD_W), .CLK_NS(CLK_NS), .SETUP_NS(SETUP_NS), .HOLD_NS(HOLD_NS),
  .HIGH_NS(HIGH_NS), .LOW_NS(LOW_NS), .STROBE_NS(STROBE_NS)
) u_chk (
  .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
  .ser_data(ser_data), .ser_clk(ser_clk), .load_n(load_n)
);

// File: tb/sdac_loader_bench.sv
module sdac_loader_bench;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + 7) / 8;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int LOW_C   = cyc(120);          // max(low 120, setup 40)
  localparam int HIGH_C  = cyc(90);           // max(high 90, hold 80)
  localparam int LOAD_C  = cyc(120);
  localparam int SETUP_C = cyc(40);
  localparam int HOLD_C  = cyc(80);
  localparam int BIT_C   = LOW_C + HIGH_C;
  localparam int SHIFT_C = 12 * BIT_C;
  localparam int TOTAL_C = SHIFT_C + LOAD_C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0;
  logic [11:0] word_data = 12'h000;
  logic        word_ready, ser_data, ser_clk, load_n, busy;

  always #4 clk = ~clk;

  sdac_loader u_sdac_loader (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .ser_data(ser_data), .ser_clk(ser_clk),
    .load_n(load_n), .busy(busy)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---- reference model, advanced on each rising edge from bench inputs
  int          pos = -1;
  logic        m_rst = 1'b1;
  logic [11:0] cur = 12'h000;
  logic [11:0] expq[$];

  always @(posedge clk) begin
    m_rst = rst;
    if (rst) begin
      pos = -1;
      expq.delete();
    end else if (pos < 0) begin
      if (word_valid) begin
        pos = 0;
        cur = word_data;
        expq.push_back(word_data);
      end
    end else begin
      pos++;
      if (pos == TOTAL_C) pos = -1;
    end
  end

  // ---- cycle-by-cycle comparison
  always @(negedge clk) begin
    if (!m_rst) begin
      int e_clk, e_ldn, e_rdy;
      e_rdy = (pos < 0) ? 1 : 0;
      e_clk = (pos >= 0 && pos < SHIFT_C && (pos % BIT_C) >= LOW_C) ? 1 : 0;
      e_ldn = (pos >= SHIFT_C) ? 0 : 1;
      chk(word_ready === e_rdy[0], "R1 ready", int'(word_ready), e_rdy);
      chk(busy === ~e_rdy[0], "R2 busy", int'(busy), 1 - e_rdy);
      chk(ser_clk === e_clk[0], "R8 shift clock timing", int'(ser_clk), e_clk);
      chk(load_n === e_ldn[0], "R7 load strobe timing", int'(load_n), e_ldn);
      if (pos >= 0 && pos < SHIFT_C)
        chk(ser_data === cur[11 - pos / BIT_C], "R3 bit order",
            int'(ser_data), int'(cur[11 - pos / BIT_C]));
    end
  end

  // ---- receiver model of the converter
  logic        p_clk = 1'b0, p_ldn = 1'b1, p_dat = 1'b0;
  int          lo_n = 0, hi_n = 0, ld_n = 0, stab = 0, since_rise = 0, bits = 0;
  bit          rise_seen = 0;
  logic [11:0] rx = 12'h000;
  logic [11:0] dac_reg = 12'h000;

  always @(negedge clk) begin
    if (m_rst) begin
      bits = 0; rise_seen = 0; lo_n = 0; hi_n = 0; ld_n = 0; stab = 0;
    end else begin
      if (ser_data !== p_dat) begin
        chk(!ser_clk, "R4 data changed with clock high", int'(ser_clk), 0);
        if (rise_seen) chk(since_rise >= HOLD_C, "R6 hold", since_rise, HOLD_C);
        stab = 0;
      end
      if (ser_clk && !p_clk) begin
        chk(stab >= SETUP_C, "R5 setup", stab, SETUP_C);
        chk(lo_n >= LOW_C, "R5 low width", lo_n, LOW_C);
        rx = {rx[10:0], ser_data};
        bits++;
        rise_seen = 1;
        since_rise = 0;
      end
      if (!ser_clk && p_clk) chk(hi_n == HIGH_C, "R6 high width", hi_n, HIGH_C);
      if (!load_n && p_ldn) begin
        chk(bits == 12, "R3 edges before strobe", bits, 12);
        chk(!ser_clk, "R7 strobe with clock low", int'(ser_clk), 0);
        if (expq.size() == 0) begin
          chk(1'b0, "R2 strobe without accepted word", int'(rx), 0);
        end else begin
          chk(rx == expq[0], "R3 received word", int'(rx), int'(expq[0]));
          void'(expq.pop_front());
        end
        dac_reg = rx;
        bits = 0;
      end
      if (load_n && !p_ldn) chk(ld_n == LOAD_C, "R7 strobe width", ld_n, LOAD_C);
      if (ser_clk) begin hi_n++; lo_n = 0; end
      else begin lo_n++; hi_n = 0; end
      if (!load_n) ld_n++; else ld_n = 0;
      stab++;
      since_rise++;
    end
    p_clk = ser_clk; p_ldn = load_n; p_dat = ser_data;
  end

  // ---- stimulus
  task automatic send(input logic [11:0] w);
    @(negedge clk);
    word_valid = 1'b1;
    word_data  = w;
    while (!word_ready) @(negedge clk);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!word_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_idle(input string req);
    chk(ser_clk === 1'b0, req, int'(ser_clk), 0);
    chk(load_n === 1'b1, req, int'(load_n), 1);
    chk(word_ready === 1'b1, req, int'(word_ready), 1);
    chk(busy === 1'b0, req, int'(busy), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    logic [11:0] pats [6] = '{12'h000, 12'hFFF, 12'h800, 12'h001, 12'h5A5, 12'h7FE};
    repeat (3) @(negedge clk);
    check_idle("R9 reset state");
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check_idle("R1 idle without valid");

    send(12'hA5A);
    wait_idle();
    chk(dac_reg == 12'hA5A, "R3 latched word", int'(dac_reg), 'hA5A);

    foreach (pats[i]) begin
      send(pats[i]);
      wait_idle();
      chk(dac_reg == pats[i], "R3 latched pattern", int'(dac_reg), int'(pats[i]));
    end

    // valid pulsed with foreign data while busy: no effect
    send(12'h3C3);
    repeat (40) @(negedge clk);
    chk(dac_reg == 12'h7FE, "R7 old word held while shifting", int'(dac_reg), 'h7FE);
    word_valid = 1'b1;
    word_data  = 12'hC3C;
    repeat (3) @(negedge clk);
    word_valid = 1'b0;
    wait_idle();
    chk(dac_reg == 12'h3C3, "R2 busy-time word ignored", int'(dac_reg), 'h3C3);
    repeat (20) @(negedge clk);
    chk(word_ready === 1'b1, "R2 nothing accepted later", int'(word_ready), 1);
    chk(dac_reg == 12'h3C3, "R2 no late strobe", int'(dac_reg), 'h3C3);

    // back-to-back: second word waits on ready
    send(12'h123);
    send(12'h456);
    wait_idle();
    chk(dac_reg == 12'h456, "R2 back-to-back second word", int'(dac_reg), 'h456);

    // reset in the middle of a word
    send(12'hBEE);
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R9 reset mid-word");
    chk(dac_reg == 12'h456, "R9 no strobe on reset", int'(dac_reg), 'h456);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    send(12'h9C6);
    wait_idle();
    chk(dac_reg == 12'h9C6, "R8 word after reset", int'(dac_reg), 'h9C6);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog expired: actual=hung expected=done");
    summary();
    $finish;
  end

endmodule